// File: doc/BRIEF.md
# Prioritised Core Event Latch and Nesting Controller

This block sits between a set of core event lines and the instruction sequencer. It watches sixteen event inputs for rising edges and records each one in a latch register. A mask register decides which latched events may be serviced. A pending register records every event that has been handed to the core and not yet returned from, so nested service levels are visible as several set bits. The lowest-numbered latched, unmasked event is the most urgent one. It is handed to the core only when it outranks every event already pending. In that case a one-cycle grant strobe carries its index.

When the core finishes servicing an event, it pulses a return input, and the most urgent pending level is retired. Events numbered at or above a configurable boundary are general-purpose. These are further gated by a global enable, which is set and cleared by two command inputs. A small register port lets supervisor code read the three registers and write the latch and mask registers.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After reset the latch, mask and pending registers are all zero, the global enable is off, `grant_vld` is low and `reg_rdata` is zero.
- R2: A 0-to-1 change on `evt_in[i]` that is present before clock edge k sets latch bit i after edge k+1. A level held high is captured only once.
- R3: A latched event that can be accepted sets its pending bit and clears its latch bit at edge k+2. `grant_vld` is high and `grant_idx` equals i for exactly that one cycle.
- R4: An event whose mask bit is 0 still latches but is never accepted.
- R5: A write with `reg_sel`=0 changes only those latch bits whose mask bit is 0. Bits whose mask bit is 1 keep their value. `reg_sel`=1 writes the mask register.
- R6: Among eligible events, the lowest index is accepted first. It is accepted only if its index is below the lowest set pending bit, and at most one pending bit is set per cycle.
- R7: A one-cycle `evt_ret` clears the lowest set pending bit at the next edge. A waiting event that now outranks the remaining pending bits is accepted one edge later.
- R8: Once an event's pending bit has set, a new rising edge on that input is captured in the latch again, even while the event is still pending.
- R9: Events with index at or above `GP_FIRST` are eligible only while the global enable is on. `gen_en_cmd` sets the enable and `gen_dis_cmd` clears it at the next edge. When both are high in the same cycle, disable wins.
- R10: With `sup_mode` low, writes have no effect and `reg_rdata` is zero. `reg_sel`=2 reads the pending register, which no write changes. `reg_sel`=3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 16 | Event request lines, index 0 most urgent |
| gen_en_cmd | input | 1 | Global enable command for general-purpose events |
| gen_dis_cmd | input | 1 | Global disable command for general-purpose events |
| evt_ret | input | 1 | Return-from-event pulse from the core |
| sup_mode | input | 1 | High while the core runs in supervisor mode |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 latch, 1 mask, 2 pending, 3 none |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, same cycle as `reg_rd` |
| grant_vld | output | 1 | One-cycle strobe: an event was accepted |
| grant_idx | output | 4 | Index of the accepted event |
| evt_latch | output | 16 | Latch register contents |
| evt_mask | output | 16 | Mask register contents |
| evt_pend | output | 16 | Pending register contents |

## Verification
Suppose an input rises before edge k. Its latch bit is due after edge k+1, and its pending bit, the cleared latch bit and the grant strobe are all due after edge k+2. Register writes, commands and return pulses take effect at the first edge after they are driven. Newly exposed acceptances follow one edge after that. The bench drives and samples only on falling edges and counts edges explicitly before each check. It also checks the cycle before each due point, so an early result is caught as well as a late one. Register reads are combinational and are sampled in the same half-cycle in which they are driven.

// File: rtl/evt_nest_pkg.sv
package evt_nest_pkg;
   typedef enum logic [1:0] {
      SEL_LATCH = 2'd0,
      SEL_MASK  = 2'd1,
      SEL_PEND  = 2'd2,
      SEL_NONE  = 2'd3
   } evt_reg_sel_e;
endpackage

// File: rtl/evt_edge_detect.sv
// Per-line sampling register plus history register; rise_o is high for
// one cycle after the sample register first sees a line high.
module evt_edge_detect #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] smp_q;
   logic [WIDTH-1:0] hist_q;

   for (genvar b = 0; b < WIDTH; b++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            smp_q[b]  <= 1'b0;
            hist_q[b] <= 1'b0;
         end else begin
            smp_q[b]  <= lvl_i[b];
            hist_q[b] <= smp_q[b];
         end
      end
      assign rise_o[b] = smp_q[b] & ~hist_q[b];
   end
endmodule

// File: rtl/evt_first_set.sv
// Finds the lowest-index set bit of a vector.
module evt_first_set #(
   parameter int unsigned WIDTH = 16,
   localparam int unsigned IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic             found_o,
   output logic [IW-1:0]    idx_o,
   output logic [WIDTH-1:0] onehot_o
);
   always_comb begin
      found_o  = 1'b0;
      idx_o    = '0;
      onehot_o = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
         end
      end
      if (found_o) onehot_o[idx_o] = 1'b1;
   end
endmodule

// File: rtl/evt_accept_arb.sv
// Chooses the event to accept this cycle and the pending level a return retires.
module evt_accept_arb #(
   parameter int unsigned WIDTH = 16,
   localparam int unsigned IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] elig_i,
   input  logic [WIDTH-1:0] pend_i,
   output logic             acc_o,
   output logic [IW-1:0]    acc_idx_o,
   output logic [WIDTH-1:0] acc_onehot_o,
   output logic [WIDTH-1:0] top_pend_onehot_o
);
   logic             cand_found;
   logic [IW-1:0]    cand_idx;
   logic [WIDTH-1:0] cand_onehot;
   logic             pend_found;
   logic [IW-1:0]    pend_idx;

   evt_first_set #(.WIDTH(WIDTH)) u_cand (
      .vec_i    (elig_i),
      .found_o  (cand_found),
      .idx_o    (cand_idx),
      .onehot_o (cand_onehot)
   );

   evt_first_set #(.WIDTH(WIDTH)) u_pend (
      .vec_i    (pend_i),
      .found_o  (pend_found),
      .idx_o    (pend_idx),
      .onehot_o (top_pend_onehot_o)
   );

   assign acc_o        = cand_found && (!pend_found || (cand_idx < pend_idx));
   assign acc_idx_o    = cand_idx;
   assign acc_onehot_o = acc_o ? cand_onehot : '0;
endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl
   import evt_nest_pkg::*;
#(
   parameter int unsigned NUM_EVT  = 16,
   parameter int unsigned GP_FIRST = 7,
   localparam int unsigned IW      = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               gen_en_cmd,
   input  logic               gen_dis_cmd,
   input  logic               evt_ret,
   input  logic               sup_mode,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [1:0]         reg_sel,
   input  logic [NUM_EVT-1:0] reg_wdata,
   output logic [NUM_EVT-1:0] reg_rdata,
   output logic               grant_vld,
   output logic [IW-1:0]      grant_idx,
   output logic [NUM_EVT-1:0] evt_latch,
   output logic [NUM_EVT-1:0] evt_mask,
   output logic [NUM_EVT-1:0] evt_pend
);
   if (NUM_EVT < 2 || NUM_EVT > 32) begin : g_bad_width
      $error("evt_nest_ctrl: NUM_EVT must lie in 2..32");
   end
   if (GP_FIRST > NUM_EVT) begin : g_bad_gp
      $error("evt_nest_ctrl: GP_FIRST must not exceed NUM_EVT");
   end

   localparam logic [NUM_EVT-1:0] GP_BITS = {NUM_EVT{1'b1}} << GP_FIRST;

   logic [NUM_EVT-1:0] rise;
   logic [NUM_EVT-1:0] latch_q, latch_d;
   logic [NUM_EVT-1:0] mask_q,  mask_d;
   logic [NUM_EVT-1:0] pend_q,  pend_d;
   logic               gen_en_q;
   logic [NUM_EVT-1:0] elig;
   logic               acc;
   logic [IW-1:0]      acc_idx;
   logic [NUM_EVT-1:0] acc_onehot;
   logic [NUM_EVT-1:0] top_pend_onehot;
   logic               grant_vld_q;
   logic [IW-1:0]      grant_idx_q;
   logic               wr_ok;
   logic               rd_ok;
   evt_reg_sel_e       sel;

   assign sel   = evt_reg_sel_e'(reg_sel);
   assign wr_ok = sup_mode & reg_wr;
   assign rd_ok = sup_mode & reg_rd;

   evt_edge_detect #(.WIDTH(NUM_EVT)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (evt_in),
      .rise_o (rise)
   );

   // General-purpose lines are qualified by the global enable.
   assign elig = latch_q & mask_q & (~GP_BITS | {NUM_EVT{gen_en_q}});

   evt_accept_arb #(.WIDTH(NUM_EVT)) u_arb (
      .elig_i            (elig),
      .pend_i            (pend_q),
      .acc_o             (acc),
      .acc_idx_o         (acc_idx),
      .acc_onehot_o      (acc_onehot),
      .top_pend_onehot_o (top_pend_onehot)
   );

   always_comb begin
      latch_d = latch_q;
      if (wr_ok && sel == SEL_LATCH) begin
         latch_d = (latch_q & mask_q) | (reg_wdata & ~mask_q);
      end
      latch_d = (latch_d & ~acc_onehot) | rise;
   end

   always_comb begin
      mask_d = mask_q;
      if (wr_ok && sel == SEL_MASK) mask_d = reg_wdata;
   end

   always_comb begin
      pend_d = pend_q;
      if (evt_ret) pend_d = pend_d & ~top_pend_onehot;
      pend_d = pend_d | acc_onehot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q     <= '0;
         mask_q      <= '0;
         pend_q      <= '0;
         gen_en_q    <= 1'b0;
         grant_vld_q <= 1'b0;
         grant_idx_q <= '0;
      end else begin
         latch_q     <= latch_d;
         mask_q      <= mask_d;
         pend_q      <= pend_d;
         grant_vld_q <= acc;
         if (acc) grant_idx_q <= acc_idx;
         if (gen_dis_cmd)     gen_en_q <= 1'b0;
         else if (gen_en_cmd) gen_en_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (rd_ok) begin
         unique case (sel)
            SEL_LATCH: reg_rdata = latch_q;
            SEL_MASK:  reg_rdata = mask_q;
            SEL_PEND:  reg_rdata = pend_q;
            SEL_NONE:  reg_rdata = '0;
         endcase
      end
   end

   assign grant_vld = grant_vld_q;
   assign grant_idx = grant_idx_q;
   assign evt_latch = latch_q;
   assign evt_mask  = mask_q;
   assign evt_pend  = pend_q;
endmodule

// File: rtl/evt_nest_ctrl_chk.sv
module evt_nest_ctrl_chk #(
   parameter int unsigned NUM_EVT = 16,
   localparam int unsigned IW     = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sup_mode,
   input logic [NUM_EVT-1:0] reg_rdata,
   input logic               grant_vld,
   input logic [IW-1:0]      grant_idx,
   input logic [NUM_EVT-1:0] evt_latch,
   input logic [NUM_EVT-1:0] evt_mask,
   input logic [NUM_EVT-1:0] evt_pend
);
   logic               past_ok;
   logic [NUM_EVT-1:0] below_grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign below_grant = (NUM_EVT'(1) << grant_idx) - NUM_EVT'(1);

   // R3
   pend_from_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((evt_pend & ~$past(evt_pend) & ~$past(evt_latch)) == '0));

   // R4
   pend_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((evt_pend & ~$past(evt_pend) & ~$past(evt_mask)) == '0));

   // R6
   one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> $onehot0(evt_pend & ~$past(evt_pend)));

   // R6
   grant_is_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> (evt_pend[grant_idx] && ((evt_pend & below_grant) == '0)));

   // R7
   one_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> $onehot0($past(evt_pend) & ~evt_pend));

   // R10
   user_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_mode |-> (reg_rdata == '0));
endmodule

bind evt_nest_ctrl evt_nest_ctrl_chk #(.NUM_EVT(NUM_EVT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sup_mode  (sup_mode),
   .reg_rdata (reg_rdata),
   .grant_vld (grant_vld),
   .grant_idx (grant_idx),
   .evt_latch (evt_latch),
   .evt_mask  (evt_mask),
   .evt_pend  (evt_pend)
);

// File: tb/test_evt_nest_ctrl.sv
module test_evt_nest_ctrl;
   localparam int N  = 16;
   localparam int GP = 7;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt_in = '0;
   logic          gen_en_cmd = 1'b0, gen_dis_cmd = 1'b0, evt_ret = 1'b0;
   logic          sup_mode = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic [N-1:0]  reg_wdata = '0;
   logic [N-1:0]  reg_rdata;
   logic          grant_vld;
   logic [IW-1:0] grant_idx;
   logic [N-1:0]  evt_latch, evt_mask, evt_pend;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   evt_nest_ctrl #(.NUM_EVT(N), .GP_FIRST(GP)) i_evt_nest_ctrl (
      .clk, .rst_n, .evt_in, .gen_en_cmd, .gen_dis_cmd, .evt_ret,
      .sup_mode, .reg_wr, .reg_rd, .reg_sel, .reg_wdata, .reg_rdata,
      .grant_vld, .grant_idx, .evt_latch, .evt_mask, .evt_pend
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [1:0] s, input logic [N-1:0] d, input logic sup);
      sup_mode = sup; reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      step(1);
      reg_wr = 1'b0; sup_mode = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] s, input logic sup, output logic [N-1:0] d);
      sup_mode = sup; reg_rd = 1'b1; reg_sel = s;
      #1 d = reg_rdata;
      reg_rd = 1'b0; sup_mode = 1'b0;
   endtask

   task automatic pulse_evt(input int i);
      evt_in[i] = 1'b1; step(1); evt_in[i] = 1'b0;
   endtask

   task automatic ret_once();
      evt_ret = 1'b1; step(1); evt_ret = 1'b0;
   endtask

   initial begin
      logic [N-1:0] rd;
      step(2);
      // R1 reset state
      chk("R1 latch", 32'(evt_latch), 0);
      chk("R1 mask",  32'(evt_mask),  0);
      chk("R1 pend",  32'(evt_pend),  0);
      chk("R1 grant", 32'(grant_vld), 0);
      rst_n = 1'b1;
      step(1);
      rd_reg(2'd1, 1'b1, rd);
      chk("R1 rdata mask", 32'(rd), 0);

      wr_reg(2'd1, '1, 1'b1);
      gen_en_cmd = 1'b1; step(1); gen_en_cmd = 1'b0;

      // R2 R3 sweep over every line: latch after 2 edges, pending after 3
      for (int i = 0; i < N; i++) begin
         pulse_evt(i);
         step(1);
         chk($sformatf("R2 latch line %0d", i), 32'(evt_latch), 32'(1) << i);
         chk($sformatf("R3 not early %0d", i),  32'(evt_pend), 0);
         step(1);
         chk($sformatf("R3 pend line %0d", i),  32'(evt_pend), 32'(1) << i);
         chk($sformatf("R3 latch clr %0d", i),  32'(evt_latch), 0);
         chk($sformatf("R3 grant %0d", i),      {grant_vld, 27'd0, grant_idx}, {1'b1, 27'd0, 4'(i)});
         step(1);
         chk($sformatf("R3 grant one cycle %0d", i), 32'(grant_vld), 0);
         ret_once();
         chk($sformatf("R7 ret %0d", i), 32'(evt_pend), 0);
      end

      // R2 held level gives one capture
      evt_in[2] = 1'b1; step(6);
      chk("R2 held level pend", 32'(evt_pend), 32'h4);
      ret_once(); step(4);
      chk("R2 held level no recapture", 32'(evt_pend), 0);
      evt_in[2] = 1'b0; step(2);

      // R4 R5 masked line latches but is not accepted; latch write gated by mask
      wr_reg(2'd1, ~N'(16'h0008), 1'b1);
      pulse_evt(3); step(4);
      chk("R4 masked latched", 32'(evt_latch), 32'h8);
      chk("R4 masked not pend", 32'(evt_pend), 0);
      wr_reg(2'd0, N'(16'h0020), 1'b1);
      chk("R5 write masked-set bit ignored", 32'(evt_latch), 0);
      wr_reg(2'd0, N'(16'h0008), 1'b1);
      rd_reg(2'd0, 1'b1, rd);
      chk("R5 write masked-clear bit", 32'(rd), 32'h8);
      wr_reg(2'd0, '0, 1'b1);
      chk("R5 clear masked-clear bit", 32'(evt_latch), 0);
      wr_reg(2'd1, '1, 1'b1);

      // R9 disable holds general-purpose line 10 latched; write cannot clear it
      gen_dis_cmd = 1'b1; step(1); gen_dis_cmd = 1'b0;
      pulse_evt(10); step(4);
      chk("R9 disabled not pend", 32'(evt_pend), 0);
      wr_reg(2'd0, '0, 1'b1);
      chk("R5 write ignored when mask set", 32'(evt_latch), 32'h400);
      // R8 second edge while latched, then re-capture while pending
      pulse_evt(10); step(2);
      chk("R8 still one latch", 32'(evt_latch), 32'h400);
      gen_en_cmd = 1'b1; step(1); gen_en_cmd = 1'b0;
      step(1);
      chk("R9 enable accepts", 32'(evt_pend), 32'h400);
      pulse_evt(10); step(1);
      chk("R8 recaptured while pending", 32'(evt_latch), 32'h400);
      chk("R6 equal index not nested", 32'(evt_pend), 32'h400);
      ret_once();
      chk("R7 retire 10", 32'(evt_pend), 0);
      step(1);
      chk("R8 recaptured accepted", 32'(evt_pend), 32'h400);
      ret_once();

      // R6 R7 nesting
      pulse_evt(8); step(2);
      chk("R6 pend 8", 32'(evt_pend), 32'h100);
      pulse_evt(12); step(2);
      chk("R6 lower priority waits", {16'(evt_latch), 16'(evt_pend)}, {16'h1000, 16'h0100});
      pulse_evt(4); step(2);
      chk("R6 nested pend", 32'(evt_pend), 32'h0110);
      chk("R6 nested grant", {grant_vld, 27'd0, grant_idx}, {1'b1, 27'd0, 4'd4});
      ret_once();
      chk("R7 retire top", 32'(evt_pend), 32'h0100);
      ret_once();
      chk("R7 retire 8", 32'(evt_pend), 0);
      step(1);
      chk("R7 waiting accepted", 32'(evt_pend), 32'h1000);
      ret_once();

      // R6 simultaneous edges: lowest index first
      evt_in = N'(16'h0042); step(1); evt_in = '0; step(2);
      chk("R6 lowest first", 32'(evt_pend), 32'h2);
      step(1);
      chk("R6 second not nested", 32'(evt_pend), 32'h2);
      ret_once(); step(1);
      chk("R6 second accepted", 32'(evt_pend), 32'h40);
      ret_once();

      // R10 supervisor gating and read-only pending
      wr_reg(2'd1, '0, 1'b0);
      chk("R10 user write ignored", 32'(evt_mask), 32'hFFFF);
      rd_reg(2'd1, 1'b0, rd);
      chk("R10 user read zero", 32'(rd), 0);
      wr_reg(2'd2, '1, 1'b1);
      chk("R10 pend read-only", 32'(evt_pend), 0);
      rd_reg(2'd3, 1'b1, rd);
      chk("R10 sel 3 reads zero", 32'(rd), 0);
      rd_reg(2'd1, 1'b1, rd);
      chk("R10 mask read", 32'(rd), 32'hFFFF);

      // R9 both commands: disable wins
      gen_en_cmd = 1'b1; gen_dis_cmd = 1'b1; step(1);
      gen_en_cmd = 1'b0; gen_dis_cmd = 1'b0;
      pulse_evt(12); step(4);
      chk("R9 disable wins", {16'(evt_latch), 16'(evt_pend)}, {16'h1000, 16'h0000});
      pulse_evt(6); step(2);
      chk("R9 low line unaffected", 32'(evt_pend), 32'h40);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule